// File: doc/BRIEF.md
# Two-Tier Interrupt Controller with Pin-Change Detection

This block gathers the interrupt sources of a small microcontroller and reduces them to one request line toward the CPU core. Three sources sit directly in the core control register: a timer overflow, an external interrupt pin with a selectable edge, and a port-change detector. Four further sources (EEPROM write done, ADC done, comparator change, second timer) sit behind a second tier. Each of these has its own enable bit, and all four are also gated by a shared peripheral-enable bit. A global enable gates everything.

Every source has a flag. A flag sets on its event whatever the state of the enables, and only a software write of 0 clears it. The port-change detector watches a parameterized number of port pins through a synchronizer. It compares each pin against a copy of the port that is captured whenever software reads the port, so reading the port is how software ends a change condition. An acknowledge strobe from the CPU clears the global enable on interrupt entry, and a return strobe sets it again.

Top module: `pcirq_top`

## Requirements
- R1: After reset every enable bit and every flag is 0 and `irq_req` is 0. The configuration register reads 0x80: edge select is rising and all change enables are off.
- R2: Register map on `reg_addr`. Address 0 is the core register: bit0 global enable, bit1 peripheral enable, bit2 timer enable, bit3 external-pin enable, bit4 port-change enable, bit5 timer flag, bit6 external-pin flag, bit7 port-change flag. Address 1 holds the peripheral enables and address 2 the peripheral flags, with bit i belonging to `per_evt[i]`. Address 3 is configuration: bits [NPINS-1:0] are the change enables and bit7 is the edge select. Unimplemented bits read 0.
- R3: A pulse on `tmr_evt` or `per_evt[i]` sets the matching flag at that clock edge, whether or not any enable bit is set.
- R4: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R5: With edge select at 1, a rising edge on `ext_pin` sets the external-pin flag. With edge select at 0, a falling edge sets it. An edge of the other polarity leaves the flag clear. The flag is set by the third clock edge after the pin changes.
- R6: When a pin whose change enable is 1 differs from the captured port copy, the port-change flag sets. Pins with change enable 0 have no effect on it.
- R7: A `port_rd` strobe captures the current synchronized pin levels, which are also visible on `port_level`. Until that strobe, a mismatch keeps setting the port-change flag again after software clears it. After the strobe, clearing the flag makes it stay clear.
- R8: A core source (timer, external pin, port change) raises `irq_req` when its flag and its enable are both 1 and the global enable is 1.
- R9: A peripheral source raises `irq_req` only when its flag, its own enable, the peripheral-enable bit and the global enable are all 1.
- R10: `irq_req` is registered. It rises at the clock edge after the edge at which the last qualifying bit became set.
- R11: `irq_ack` clears the global enable and `irq_ret` sets it. `irq_ack` wins over `irq_ret`, and both win over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| port_rd | input | 1 | Strobe: software reads the port, so capture it |
| port_level | output | NPINS | Synchronized port pin levels |
| pin_in | input | NPINS | Raw port pins watched for change |
| ext_pin | input | 1 | Raw external interrupt pin |
| tmr_evt | input | 1 | Timer overflow event pulse |
| per_evt | input | NPERIPH | Peripheral event pulses |
| irq_ack | input | 1 | CPU interrupt entry strobe |
| irq_ret | input | 1 | CPU return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its defaults: six change pins, four peripheral sources and a two-stage synchronizer. At this size every peripheral source can be run through all eight combinations of its own enable, the peripheral enable and the global enable. Every pin can be toggled with its change enable both on and off. All four pairings of edge select and pin direction can be applied to the external pin. The request line is checked against a value the bench derives from those bits, and the cycle of the request is checked against the one-cycle register latency.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  localparam int REG_W        = 8;
  localparam int CFG_RISE_BIT = 7;

  typedef enum logic [1:0] {
    ADDR_CORE = 2'd0,
    ADDR_PEN  = 2'd1,
    ADDR_PFLG = 2'd2,
    ADDR_CFG  = 2'd3
  } reg_addr_e;

  // core register, MSB first
  typedef struct packed {
    logic chg_flg;
    logic pin_flg;
    logic tmr_flg;
    logic chg_en;
    logic pin_en;
    logic tmr_en;
    logic per_en;
    logic glb_en;
  } core_t;

  // next state of a sticky flag: event sets, write of 0 clears, event wins
  function automatic logic flag_next(logic cur, logic evt, logic wr, logic wbit);
    return evt | (cur & ~(wr & ~wbit));
  endfunction

  function automatic logic core_hit(core_t c);
    return (c.tmr_en & c.tmr_flg) | (c.pin_en & c.pin_flg) | (c.chg_en & c.chg_flg);
  endfunction

  function automatic logic periph_hit(logic [REG_W-1:0] en, logic [REG_W-1:0] flg, logic tier);
    return tier & (|(en & flg));
  endfunction

  function automatic logic pin_mismatch(logic [REG_W-1:0] cur, logic [REG_W-1:0] snap,
                                        logic [REG_W-1:0] en);
    return |((cur ^ snap) & en);
  endfunction

endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;

  logic [CW-1:0] chain;

  // STAGES must be at least 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/pcirq_pin_edge.sv
module pcirq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);
  logic lvl, prev;

  pcirq_sync #(.W(1), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign edge_evt = rise_sel ? (lvl & ~prev) : (~lvl & prev);

  // same polarity cannot qualify on two consecutive cycles
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt ##1 $stable(rise_sel) |-> !edge_evt);
endmodule

// File: rtl/pcirq_change.sv
module pcirq_change
  import pcirq_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] en,
  input  logic             snap,
  output logic [NPINS-1:0] level,
  output logic             chg_evt
);
  logic [NPINS-1:0] snap_q;

  pcirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (snap) snap_q <= level;
  end

  assign chg_evt = pin_mismatch(REG_W'(level), REG_W'(snap_q), REG_W'(en));

  // a capture with steady pins leaves no mismatch
  assert_snap_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap ##1 (level == $past(level)) |-> !chg_evt);
endmodule

// File: rtl/pcirq_top.sv
module pcirq_top
  import pcirq_pkg::*;
#(
  parameter int NPINS       = 6,   // at most 7
  parameter int NPERIPH     = 4,   // at most 8
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               port_rd,
  output logic [NPINS-1:0]   port_level,
  input  logic [NPINS-1:0]   pin_in,
  input  logic               ext_pin,
  input  logic               tmr_evt,
  input  logic [NPERIPH-1:0] per_evt,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req
);
  reg_addr_e        addr;
  core_t            core_q, wc;
  logic             wr_core, wr_pen, wr_pflg, wr_cfg;
  logic [NPERIPH-1:0] pen_q, pflg_q;
  logic [NPINS-1:0] chen_q;
  logic             rise_q;
  logic             ext_evt, chg_evt;
  logic             hit_core, hit_per, irq_q;
  logic [REG_W-1:0] cfg_rd;

  assign addr    = reg_addr_e'(reg_addr);
  assign wc      = core_t'(reg_wdata);
  assign wr_core = reg_wr && (addr == ADDR_CORE);
  assign wr_pen  = reg_wr && (addr == ADDR_PEN);
  assign wr_pflg = reg_wr && (addr == ADDR_PFLG);
  assign wr_cfg  = reg_wr && (addr == ADDR_CFG);

  // ---------------- event sources ----------------
  pcirq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(rise_q), .edge_evt(ext_evt)
  );

  pcirq_change #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) chg_i (
    .clk(clk), .rst_n(rst_n), .pins(pin_in), .en(chen_q), .snap(port_rd),
    .level(port_level), .chg_evt(chg_evt)
  );

  // ---------------- core register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
    end else begin
      core_q.glb_en <= irq_ack ? 1'b0 : (irq_ret ? 1'b1 : (wr_core ? wc.glb_en : core_q.glb_en));
      if (wr_core) begin
        core_q.per_en <= wc.per_en;
        core_q.tmr_en <= wc.tmr_en;
        core_q.pin_en <= wc.pin_en;
        core_q.chg_en <= wc.chg_en;
      end
      core_q.tmr_flg <= flag_next(core_q.tmr_flg, tmr_evt, wr_core, wc.tmr_flg);
      core_q.pin_flg <= flag_next(core_q.pin_flg, ext_evt, wr_core, wc.pin_flg);
      core_q.chg_flg <= flag_next(core_q.chg_flg, chg_evt, wr_core, wc.chg_flg);
    end
  end

  // ---------------- enables and configuration ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q  <= '0;
      chen_q <= '0;
      rise_q <= 1'b1;
    end else begin
      if (wr_pen) pen_q <= reg_wdata[NPERIPH-1:0];
      if (wr_cfg) begin
        chen_q <= reg_wdata[NPINS-1:0];
        rise_q <= reg_wdata[CFG_RISE_BIT];
      end
    end
  end

  // ---------------- peripheral flags, one per source ----------------
  for (genvar i = 0; i < NPERIPH; i++) begin : g_per
    logic flg_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_r <= 1'b0;
      else        flg_r <= flag_next(flg_r, per_evt[i], wr_pflg, reg_wdata[i]);
    end
    assign pflg_q[i] = flg_r;

    assert_per_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      per_evt[i] |=> flg_r);
  end

  // ---------------- request ----------------
  assign hit_core = core_hit(core_q);
  assign hit_per  = periph_hit(REG_W'(pen_q), REG_W'(pflg_q), core_q.per_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= core_q.glb_en & (hit_core | hit_per);
  end
  assign irq_req = irq_q;

  // ---------------- read mux ----------------
  always_comb begin
    cfg_rd               = REG_W'(chen_q);
    cfg_rd[CFG_RISE_BIT] = rise_q;
    unique case (addr)
      ADDR_CORE: reg_rdata = core_q;
      ADDR_PEN:  reg_rdata = REG_W'(pen_q);
      ADDR_PFLG: reg_rdata = REG_W'(pflg_q);
      default:   reg_rdata = cfg_rd;
    endcase
  end

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (core_q == '0 && pflg_q == '0 && !irq_req));

  assert_tmr_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_q.tmr_flg) |-> $past(wr_core && !wc.tmr_flg));

  assert_pin_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> core_q.pin_flg);

  assert_chg_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> core_q.chg_flg);

  assert_req_needs_glb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(core_q.glb_en));

  assert_per_needs_tier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(hit_core)) |-> $past(core_q.per_en && |(pen_q & pflg_q)));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !core_q.glb_en);
endmodule

// File: tb/pcirq_top_tb_top.sv
module pcirq_top_tb_top;
  localparam int NPINS = 6;
  localparam int NPER  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [7:0]      reg_wdata = 8'd0;
  logic [7:0]      reg_rdata;
  logic            port_rd = 1'b0;
  logic [NPINS-1:0] port_level;
  logic [NPINS-1:0] pin_in = '0;
  logic            ext_pin = 1'b0;
  logic            tmr_evt = 1'b0;
  logic [NPER-1:0] per_evt = '0;
  logic            irq_ack = 1'b0;
  logic            irq_ret = 1'b0;
  logic            irq_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pcirq_top #(.NPINS(NPINS), .NPERIPH(NPER), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_rd(port_rd),
    .port_level(port_level), .pin_in(pin_in), .ext_pin(ext_pin),
    .tmr_evt(tmr_evt), .per_evt(per_evt), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap_port();
    @(negedge clk); port_rd = 1'b1;
    @(negedge clk); port_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // ---------------- reset ----------------
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    rd(2'd0, v); chk("R1 core reg", v, 8'h00);
    rd(2'd1, v); chk("R1 periph enables", v, 8'h00);
    rd(2'd2, v); chk("R1 periph flags", v, 8'h00);
    rd(2'd3, v); chk("R1 config", v, 8'h80);
    chk("R1 irq_req", {7'd0, irq_req}, 8'h00);

    // ---------------- register map ----------------
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 periph enable width", v, 8'h0F);
    wr(2'd3, 8'h3F); rd(2'd3, v); chk("R2 config fields", v, 8'h3F);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 config unused bit", v, 8'hBF);
    wr(2'd0, 8'h1F); rd(2'd0, v); chk("R2 core enables", v, 8'h1F);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h80);

    // ---------------- timer source: enables x global ----------------
    for (int m = 0; m < 4; m++) begin
      logic glb, ten;
      glb = m[0]; ten = m[1];
      wr(2'd0, {5'd0, ten, 1'b0, glb});
      @(negedge clk); tmr_evt = 1'b1;
      @(negedge clk); tmr_evt = 1'b0;
      rd(2'd0, v); chk("R3 timer flag sets regardless of enables", {7'd0, v[5]}, 8'h01);
      chk("R10 irq_req not yet high", {7'd0, irq_req}, 8'h00);
      wait_n(1);
      chk("R8 timer request", {7'd0, irq_req}, {7'd0, glb & ten});
      wr(2'd0, {5'd0, ten, 1'b0, glb});
      rd(2'd0, v); chk("R4 write 0 clears timer flag", {7'd0, v[5]}, 8'h00);
    end

    // writing 1 to a clear flag has no effect
    wr(2'd0, 8'hE0); rd(2'd0, v); chk("R4 write 1 no effect", v, 8'h00);
    // event in same cycle as clearing write wins
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; tmr_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tmr_evt = 1'b0;
    rd(2'd0, v); chk("R4 event beats clear", {7'd0, v[5]}, 8'h01);
    wr(2'd0, 8'h00);

    // ---------------- peripheral sources: own x tier x global ----------------
    for (int i = 0; i < NPER; i++) begin
      for (int m = 0; m < 8; m++) begin
        logic own, tier, glb;
        logic [7:0] en8;
        own = m[0]; tier = m[1]; glb = m[2];
        en8 = 8'(own) << i;
        wr(2'd1, en8);
        wr(2'd0, {6'd0, tier, glb});
        @(negedge clk); per_evt[i] = 1'b1;
        @(negedge clk); per_evt = '0;
        rd(2'd2, v); chk("R3 periph flag sets", v, 8'h01 << i);
        wait_n(1);
        chk("R9 periph request", {7'd0, irq_req}, {7'd0, own & tier & glb});
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R4 periph flag clear", v, 8'h00);
      end
    end
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);

    // ---------------- external pin: edge select x direction ----------------
    for (int sel = 0; sel < 2; sel++) begin
      for (int rising = 0; rising < 2; rising++) begin
        logic expv;
        expv = (sel == rising);
        @(negedge clk); ext_pin = (rising == 0);
        wr(2'd3, {sel[0], 7'd0});
        wait_n(5);
        wr(2'd0, 8'h09);              // global + pin enable, flags cleared
        rd(2'd0, v); chk("R5 pin flag cleared before edge", {7'd0, v[6]}, 8'h00);
        @(negedge clk); ext_pin = (rising == 1);
        wait_n(2);
        rd(2'd0, v); chk("R5 pin flag not before third edge", {7'd0, v[6]}, 8'h00);
        wait_n(1);
        rd(2'd0, v); chk("R5 pin flag by edge select", {7'd0, v[6]}, {7'd0, expv});
        wait_n(1);
        chk("R8 pin request", {7'd0, irq_req}, {7'd0, expv});
      end
    end
    ext_pin = 1'b0;
    wr(2'd3, 8'h80); wait_n(5); wr(2'd0, 8'h00);

    // ---------------- port change: each pin, enabled and not ----------------
    for (int p = 0; p < NPINS; p++) begin
      for (int en = 0; en < 2; en++) begin
        wr(2'd3, 8'h80 | (8'(en) << p));
        snap_port();
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R7 no flag after capture", {7'd0, v[7]}, 8'h00);
        @(negedge clk); pin_in[p] = ~pin_in[p];
        wait_n(4);
        rd(2'd0, v); chk("R6 change flag per enable", {7'd0, v[7]}, 8'(en));
        chk("R7 port level", 8'(port_level), 8'(pin_in));
        if (en == 1) begin
          wr(2'd0, 8'h00);
          rd(2'd0, v); chk("R7 mismatch sets flag again", {7'd0, v[7]}, 8'h01);
          wr(2'd0, 8'h11);            // global + change enable
          wait_n(1);
          chk("R8 change request", {7'd0, irq_req}, 8'h01);
        end
        snap_port();
        wr(2'd0, 8'h00);
        wait_n(2);
        rd(2'd0, v); chk("R7 capture ends mismatch", {7'd0, v[7]}, 8'h00);
      end
    end
    wr(2'd3, 8'h80);

    // ---------------- acknowledge and return ----------------
    wr(2'd0, 8'h01);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(2'd0, v); chk("R11 ack clears global", {7'd0, v[0]}, 8'h00);
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    rd(2'd0, v); chk("R11 ret sets global", {7'd0, v[0]}, 8'h01);
    @(negedge clk); irq_ack = 1'b1; irq_ret = 1'b1;
    @(negedge clk); irq_ack = 1'b0; irq_ret = 1'b0;
    rd(2'd0, v); chk("R11 ack beats ret", {7'd0, v[0]}, 8'h00);
    @(negedge clk); irq_ack = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
    @(negedge clk); irq_ack = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R11 ack beats write", {7'd0, v[0]}, 8'h00);
    @(negedge clk); irq_ret = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
    @(negedge clk); irq_ret = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R11 ret beats write", {7'd0, v[0]}, 8'h01);

    // request drops when global enable is cleared by acknowledge
    wr(2'd0, 8'h05);
    @(negedge clk); tmr_evt = 1'b1;
    @(negedge clk); tmr_evt = 1'b0;
    wait_n(1);
    chk("R10 request after flag", {7'd0, irq_req}, 8'h01);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    wait_n(1);
    chk("R8 request gated by global", {7'd0, irq_req}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule